// File: doc/BRIEF.md
# Center-Aligned PWM Channel with Dead-Time Insertion

This block drives one PWM pin from a shared up/down time base that a neighbouring block supplies. Each time-base period crosses the duty value twice, once counting up and once counting down, so an undelayed output would be a pulse centred on the count peak. The block adds a dead time to one side of that pulse. While the dead time runs, a small local counter replaces the shared count as the compare source. The local counter advances on the same prescaler tick as the shared count, so duty and dead-time values use one time scale.

Dead time can be added at the leading edge, which delays the rising edge and shortens the pulse. It can instead be added at the trailing edge, which delays the falling edge and lengthens the pulse. A sticky event flag records output edges. It records either trailing edges only or both edges, and a strobe clears it. Dropping the enable parks the pin at its inactive level and restarts the sequence.

Top module: `cpwm_deadtime`

## Requirements
- R1: During reset, and one clock after `enable` is low, `pwm_out` equals the complement of `pol`. Reset clears `flag`. After `enable` returns high, the sequence restarts from its first duty match.
- R2: Timing is counted in ticks, numbered from 0 at the first tick after enable. A compare takes effect at the clock edge that ends its tick cycle. With `lead_mode`=1, the pin goes active (`pwm_out`==`pol`) D ticks after the rising-count duty match, where D is the value of `dead`. It goes inactive at the falling-count duty match.
- R3: With `lead_mode`=1, the active width in ticks equals 2·(peak − duty) − D. That is the undelayed width minus D.
- R4: With `lead_mode`=0, the pin goes active at the rising-count duty match and goes inactive D ticks after the falling-count duty match. The width equals the undelayed width plus D.
- R5: The dead-time counter advances only on cycles with `tick` high, never on the clock cycles between ticks.
- R6: A `dead` value of 0 behaves as a one-tick dead time.
- R7: With `flag_both`=0, `flag` is set only when the pin goes inactive.
- R8: With `flag_both`=1, `flag` is set when the pin goes active and when it goes inactive.
- R9: `flag` stays set until `flag_clr` is high at a clock edge. If a set and a clear occur at the same edge, the flag ends set.
- R10: With `pol`=0 the pin's active level is 0. Edge timing is the same as with `pol`=1.
- R11: The sequence repeats every period with no outside action. New `duty` and `dead` values written between periods are used from the next match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel run enable; low parks the pin and restarts the sequence |
| tick | input | 1 | Prescaler tick shared with the time base |
| tb_count | input | CW | Shared up/down time-base value |
| duty | input | CW | Duty compare value |
| dead | input | CW | Dead time in ticks |
| lead_mode | input | 1 | 1: leading-edge dead time, 0: trailing-edge dead time |
| flag_both | input | 1 | 1: flag on both edges, 0: flag on inactive-going edge only |
| pol | input | 1 | Active output level |
| flag_clr | input | 1 | Flag clear strobe |
| pwm_out | output | 1 | PWM pin |
| flag | output | 1 | Sticky edge event flag |

## Verification
A triangle count with a peak of 20 is applied with one idle clock between ticks. The edge positions in each of two periods are compared with values derived from duty and dead time. Leading and trailing runs with the same duty and dead time tell apart which edge moves and in which direction. A run with a different duty and dead time confirms that the width tracks both values. A zero dead time, an inverted polarity and a mid-run change of duty and dead time separate the corner cases. A clear strobe that coincides with a flag-setting edge, and an enable drop in mid-pulse, cover the flag priority and the restart behaviour.

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          tick,
  input  logic [CW-1:0] tb_count,
  input  logic [CW-1:0] duty,
  input  logic [CW-1:0] dead,
  input  logic          lead_mode,
  input  logic          flag_both,
  input  logic          pol,
  input  logic          flag_clr,
  output logic          pwm_out,
  output logic          flag
);

  localparam logic [1:0] PH_FIRST  = 2'd0;
  localparam logic [1:0] PH_SECOND = 2'd1;
  localparam logic [1:0] PH_DEAD   = 2'd2;

  logic [1:0]  phase;
  logic [CW-1:0] lc;
  logic        act;
  logic        on_local;
  logic [CW:0] lc_inc;
  logic        duty_hit, dead_hit;
  logic        go_active, go_idle;

  assign on_local  = (phase == PH_DEAD);
  assign lc_inc    = {1'b0, lc} + (CW+1)'(1);
  assign duty_hit  = enable & tick & ~on_local & (tb_count == duty);
  assign dead_hit  = enable & tick & on_local & (lc_inc >= {1'b0, dead});

  assign go_active = (duty_hit & ~lead_mode & (phase == PH_FIRST)) | (dead_hit & lead_mode);
  assign go_idle   = (duty_hit & lead_mode & (phase == PH_SECOND)) | (dead_hit & ~lead_mode);

  assign pwm_out = act ? pol : ~pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_FIRST;
      lc    <= '0;
      act   <= 1'b0;
    end else if (!enable) begin
      phase <= PH_FIRST;
      lc    <= '0;
      act   <= 1'b0;
    end else begin
      case (phase)
        PH_FIRST: if (duty_hit) begin
          phase <= lead_mode ? PH_DEAD : PH_SECOND;
          lc    <= '0;
        end
        PH_SECOND: if (duty_hit) begin
          phase <= lead_mode ? PH_FIRST : PH_DEAD;
          lc    <= '0;
        end
        PH_DEAD: begin
          if (dead_hit) phase <= lead_mode ? PH_SECOND : PH_FIRST;
          else if (tick) lc <= lc_inc[CW-1:0];
        end
        default: phase <= PH_FIRST;
      endcase
      if (go_active)    act <= 1'b1;
      else if (go_idle) act <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              flag <= 1'b0;
    else if (go_idle | (flag_both & go_active)) flag <= 1'b1;
    else if (flag_clr)                       flag <= 1'b0;
  end

endmodule

// File: rtl/cpwm_deadtime_chk.sv
module cpwm_deadtime_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic tick,
  input logic pol,
  input logic flag_both,
  input logic flag_clr,
  input logic pwm_out,
  input logic flag
);

  // R1
  parked_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> pwm_out != pol);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> flag);

  // R9
  flag_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !tick |=> !flag);

  // R8
  flag_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) && $stable(pol) |-> pwm_out != $past(pwm_out));

  // R7
  flag_trail_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) && !$past(flag_both) |-> pwm_out != pol);

  // R5
  edge_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pol) && $past(enable) && pwm_out != $past(pwm_out) |-> $past(tick));

endmodule

bind cpwm_deadtime cpwm_deadtime_chk chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .pol(pol),
  .flag_both(flag_both), .flag_clr(flag_clr), .pwm_out(pwm_out), .flag(flag)
);

// File: tb/cpwm_deadtime_tb_top.sv
module cpwm_deadtime_tb_top;
  localparam int CW = 16;
  localparam time CLK_P = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, tick = 1'b0;
  logic [CW-1:0] tb_count = '0, duty = '0, dead = '0;
  logic lead_mode = 1'b0, flag_both = 1'b0, pol = 1'b1, flag_clr = 1'b0;
  logic pwm_out, flag;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  cpwm_deadtime #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .tb_count(tb_count),
    .duty(duty), .dead(dead), .lead_mode(lead_mode), .flag_both(flag_both),
    .pol(pol), .flag_clr(flag_clr), .pwm_out(pwm_out), .flag(flag)
  );

  task automatic chk(input bit ok, input string tg, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tg, act, exp);
    end
  endtask

  function automatic int tri_val(input int n, input int p);
    int m = n % (2*p);
    return (m <= p) ? m : 2*p - m;
  endfunction

  task automatic prep();
    @(negedge clk); enable = 1'b0; flag_clr = 1'b1; tick = 1'b0;
    @(negedge clk); enable = 1'b1; flag_clr = 1'b0;
  endtask

  task automatic step(input int ti, input int p, input bit clr_tick, input bit clr_gap);
    tick = 1'b1; tb_count = CW'(tri_val(ti, p)); flag_clr = clr_tick;
    @(negedge clk); tick = 1'b0; flag_clr = clr_gap;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic run_wave(input bit lead, input bit both, input bit pl, input int p,
                          input int d1, input int dt1, input int d2, input int dt2,
                          input string tg);
    int er[2], ef[2];
    int nr = 0, nf = 0;
    bit prev = 1'b0;
    for (int k = 0; k < 2; k++) begin
      int du = k ? d2 : d1;
      int dd = k ? dt2 : dt1;
      int de = (dd == 0) ? 1 : dd;
      int base = 2*p*k;
      er[k] = lead ? base + du + de + 1 : base + du + 1;
      ef[k] = lead ? base + 2*p - du + 1 : base + 2*p - du + de + 1;
    end
    lead_mode = lead; flag_both = both; pol = pl; duty = CW'(d1); dead = CW'(dt1);
    prep();
    for (int ti = 0; ti <= 4*p + 2; ti++) begin
      bit cur = (pwm_out == pol);
      bit clr = 1'b0;
      if (ti == 2*p) begin duty = CW'(d2); dead = CW'(dt2); end
      if (cur && !prev) begin
        if (nr < 2) chk(ti == er[nr], {tg, " rise"}, ti, er[nr]);
        chk(flag == both, both ? "R8 flag on rise" : "R7 no flag on rise", flag, both);
        nr++; clr = 1'b1;
      end
      if (!cur && prev) begin
        if (nf < 2) chk(ti == ef[nf], {tg, " fall"}, ti, ef[nf]);
        chk(flag == 1'b1, "R7 R8 flag on fall", flag, 1);
        nf++; clr = 1'b1;
      end
      prev = cur;
      step(ti, p, 1'b0, clr);
    end
    chk(nr == 2, {tg, " R11 rise count"}, nr, 2);
    chk(nf == 2, {tg, " R11 fall count"}, nf, 2);
  endtask

  task automatic t_reset();
    chk(pwm_out == 1'b0, "R1 reset pin pol=1", pwm_out, 0);
    chk(flag == 1'b0, "R1 reset flag", flag, 0);
    pol = 1'b0; #1;
    chk(pwm_out == 1'b1, "R1 reset pin pol=0", pwm_out, 1);
    pol = 1'b1;
  endtask

  task automatic t_set_wins();
    lead_mode = 1'b1; flag_both = 1'b0; pol = 1'b1; duty = 16'd8; dead = 16'd3;
    prep();
    for (int ti = 0; ti <= 34; ti++) begin
      if (ti == 33) begin
        chk(flag == 1'b1, "R9 set beats clear", flag, 1);
        chk(pwm_out == 1'b0, "R2 fall at set-wins edge", pwm_out, 0);
      end
      if (ti == 34) chk(flag == 1'b0, "R9 clear strobe", flag, 0);
      step(ti, 20, ti == 32, ti == 33);
    end
  endtask

  task automatic t_disable();
    lead_mode = 1'b1; flag_both = 1'b0; pol = 1'b1; duty = 16'd8; dead = 16'd3;
    prep();
    for (int ti = 0; ti < 14; ti++) step(ti, 20, 1'b0, 1'b0);
    chk(pwm_out == 1'b1, "R2 active before disable", pwm_out, 1);
    enable = 1'b0;
    @(negedge clk);
    chk(pwm_out == 1'b0, "R1 parked on disable", pwm_out, 0);
    run_wave(1'b1, 1'b0, 1'b1, 20, 8, 3, 8, 3, "R1 restart");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    run_wave(1'b1, 1'b0, 1'b1, 20, 8, 3, 8, 3, "R2 R3 R5 lead");
    run_wave(1'b0, 1'b1, 1'b1, 20, 8, 3, 8, 3, "R4 R5 trail");
    run_wave(1'b1, 1'b1, 1'b0, 20, 8, 0, 8, 0, "R6 R10 lead dead0 pol0");
    run_wave(1'b0, 1'b0, 1'b1, 20, 8, 3, 5, 2, "R11 trail update");
    run_wave(1'b1, 1'b0, 1'b1, 20, 10, 6, 10, 6, "R3 lead wide dead");
    t_set_wins();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule